// File: doc/BRIEF.md
# ALU Stage with Condition Flag

This block is the arithmetic stage of a stack-oriented processor core. Each cycle it takes two 32-bit operands: a register operand `opa_i` and a stack-top or literal operand `opb_i`. It produces a result through four stages:

- an optional one-bit left shift of the register operand;
- a logic or arithmetic function;
- an optional one-bit right shift of the function output;
- an optional substitution of the whole result by the condition flag, spread over every bit.

A single flag register holds the block's state. An instruction may load it from one of sixteen conditions computed on the function output, from the bit shifted out on the left, or from the bit shifted out on the right. If the instruction asks for no load, the flag keeps its value. The stored flag feeds several places:

- the carry input, for multiword arithmetic;
- a pair of conditional add and subtract operations, used to build multiply steps (two cycles per bit) and divide steps (three cycles per bit) in software;
- a branch-taken output, which is true when the flag is 0.

When the flag word is placed on the result, it uses the flag value being loaded in the same instruction. A compare can therefore write its truth value straight to the stack.

Top module: `alu_flag_unit`

## Requirements
- R1: With `op_i`=0 (logic), each result bit i equals `lfn_i[{opa'[i], opb_i[i]}]`, where opa' is the register operand after the left shifter. For example, 4'b1000 gives AND, 4'b0110 gives XOR and 4'b1100 passes opa'.
- R2: `op_i`=1 gives opa' + opb_i + cin, and `op_i`=2 gives opa' + ~opb_i + cin. The carry-in is chosen by `cin_sel_i`: 0 gives zero, 1 gives one, 2 gives the stored flag, 3 gives the inverted stored flag.
- R3: When `shl_i`=1, opa' = {opa_i[30:0],0}, and the left shift-out bit is opa_i[31]. Otherwise opa' = opa_i.
- R4: When `shr_i`=1, the result is {carry-out, f[31:1]}, where f is the function output. The right shift-out bit is always f[0]. For logic and pass-through operations the carry-out is 0.
- R5: `op_i`=3 computes opa' + opb_i (carry-in 0) when the stored flag is 1, and passes opa' through with carry 0 when the flag is 0. `op_i`=4 computes opa' - opb_i when the flag is 1 and passes opa' otherwise.
- R6: The conditions are evaluated on f with its carry C and signed overflow V; Z and N are its zero and sign bits. `cond_sel_i` selects among them:

  | Code | Condition | Code | Condition |
  |------|-----------|------|-----------|
  | 0 | false | 8 | V |
  | 1 | true | 9 | !V |
  | 2 | Z | 10 | N^V (signed less) |
  | 3 | !Z | 11 | !(N^V) |
  | 4 | N | 12 | !C\|Z |
  | 5 | !N | 13 | C&!Z |
  | 6 | C | 14 | Z\|(N^V) |
  | 7 | !C (unsigned less) | 15 | !Z&!(N^V) |

- R7: At a clock edge the flag loads from one of three sources chosen by `flag_ld_i`: 1 loads the selected condition, 2 loads the left shift-out bit, 3 loads the right shift-out bit.
- R8: With `flag_ld_i`=0 the flag keeps its value.
- R9: `flag_word_o` is 32 copies of the flag value being loaded in this cycle, or of the held flag when no load is requested. When `fw_sel_i`=1, `res_o` equals `flag_word_o`.
- R10: `br_take_o` is the inverse of the stored flag and `flag_o` is the stored flag.
- R11: After reset the flag is 0.
- R12: Op codes 5 to 7 pass opa' through with carry and overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opa_i | input | 32 | Register operand (left-shiftable) |
| opb_i | input | 32 | Stack-top or literal operand |
| op_i | input | 3 | Function select |
| lfn_i | input | 4 | Logic truth table |
| cin_sel_i | input | 2 | Carry-in source |
| shl_i | input | 1 | Enable left shift of opa_i |
| shr_i | input | 1 | Enable right shift of function output |
| cond_sel_i | input | 4 | Condition select |
| flag_ld_i | input | 2 | Flag load source, 0 holds |
| fw_sel_i | input | 1 | Put the flag word on the result |
| res_o | output | 32 | Result |
| flag_word_o | output | 32 | Flag as an all-zeros or all-ones word |
| flag_o | output | 1 | Stored flag |
| br_take_o | output | 1 | Conditional branch taken (flag is 0) |

## Verification
The bench builds the block with its default width of 32. This makes the bench's vectors land on the real sign bit 31 and carry position 32. With that width, signed overflow at 0x7FFFFFFF+1 can be reached, as can an unsigned wrap at 0xFFFFFFFF+1. The bench also checks the bits shifted out at both ends, and multiply-step results whose carry refills bit 31.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    typedef enum logic [2:0] {
        OP_LOGIC = 3'd0,
        OP_ADD   = 3'd1,
        OP_SUB   = 3'd2,
        OP_CADD  = 3'd3,
        OP_CSUB  = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        FLD_HOLD = 2'd0,
        FLD_COND = 2'd1,
        FLD_LSH  = 2'd2,
        FLD_RSH  = 2'd3
    } flag_ld_e;

    typedef enum logic [1:0] {
        CIN_ZERO  = 2'd0,
        CIN_ONE   = 2'd1,
        CIN_FLAG  = 2'd2,
        CIN_NFLAG = 2'd3
    } cin_sel_e;

    typedef struct packed {
        logic carry;
        logic ovf;
    } alu_stat_t;

    typedef struct packed {
        logic flag;
    } flag_state_t;

endpackage

// File: rtl/alu_lshift.sv
module alu_lshift #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic         en_i,
    output logic [W-1:0] a_o,
    output logic         out_bit_o
);
    always_comb begin
        if (en_i) begin
            a_o       = {a_i[W-2:0], 1'b0};
            out_bit_o = a_i[W-1];
        end else begin
            a_o       = a_i;
            out_bit_o = 1'b0;
        end
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_flag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [2:0]   op_i,
    input  logic [3:0]   lfn_i,
    input  logic         cin_i,
    input  logic         flag_i,
    output logic [W-1:0] res_o,
    output alu_stat_t    stat_o
);
    localparam int SW = W + 1;

    logic [W-1:0]  lres;
    logic [W-1:0]  bop;
    logic          cin_eff;
    logic          do_arith;
    logic [SW-1:0] sum;

    // per-bit truth-table lookup
    for (genvar i = 0; i < W; i++) begin : g_logic
        assign lres[i] = lfn_i[{a_i[i], b_i[i]}];
    end

    always_comb begin
        do_arith = 1'b0;
        bop      = b_i;
        cin_eff  = 1'b0;
        unique case (op_i)
            OP_ADD:  begin do_arith = 1'b1; bop = b_i;  cin_eff = cin_i; end
            OP_SUB:  begin do_arith = 1'b1; bop = ~b_i; cin_eff = cin_i; end
            OP_CADD: begin do_arith = flag_i; bop = b_i;  cin_eff = 1'b0; end
            OP_CSUB: begin do_arith = flag_i; bop = ~b_i; cin_eff = 1'b1; end
            default: ;
        endcase
        sum = {1'b0, a_i} + {1'b0, bop} + {{(SW-1){1'b0}}, cin_eff};
    end

    always_comb begin
        if (do_arith) begin
            res_o        = sum[W-1:0];
            stat_o.carry = sum[W];
            stat_o.ovf   = (a_i[W-1] == bop[W-1]) && (sum[W-1] != a_i[W-1]);
        end else begin
            res_o        = (op_i == OP_LOGIC) ? lres : a_i;
            stat_o.carry = 1'b0;
            stat_o.ovf   = 1'b0;
        end
    end
endmodule

// File: rtl/alu_rshift.sv
module alu_rshift #(
    parameter int W = 32
) (
    input  logic [W-1:0] r_i,
    input  logic         fill_i,
    input  logic         en_i,
    output logic [W-1:0] r_o,
    output logic         out_bit_o
);
    assign out_bit_o = r_i[0];
    assign r_o       = en_i ? {fill_i, r_i[W-1:1]} : r_i;
endmodule

// File: rtl/alu_cond.sv
module alu_cond
    import alu_flag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] f_i,
    input  alu_stat_t    stat_i,
    input  logic [3:0]   sel_i,
    output logic         cond_o
);
    logic z, n, c, v, lt;

    always_comb begin
        z  = (f_i == '0);
        n  = f_i[W-1];
        c  = stat_i.carry;
        v  = stat_i.ovf;
        lt = n ^ v;
        unique case (sel_i)
            4'd0:  cond_o = 1'b0;
            4'd1:  cond_o = 1'b1;
            4'd2:  cond_o = z;
            4'd3:  cond_o = !z;
            4'd4:  cond_o = n;
            4'd5:  cond_o = !n;
            4'd6:  cond_o = c;
            4'd7:  cond_o = !c;
            4'd8:  cond_o = v;
            4'd9:  cond_o = !v;
            4'd10: cond_o = lt;
            4'd11: cond_o = !lt;
            4'd12: cond_o = !c || z;
            4'd13: cond_o = c && !z;
            4'd14: cond_o = z || lt;
            default: cond_o = !z && !lt;
        endcase
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic [2:0]   op_i,
    input  logic [3:0]   lfn_i,
    input  logic [1:0]   cin_sel_i,
    input  logic         shl_i,
    input  logic         shr_i,
    input  logic [3:0]   cond_sel_i,
    input  logic [1:0]   flag_ld_i,
    input  logic         fw_sel_i,
    output logic [W-1:0] res_o,
    output logic [W-1:0] flag_word_o,
    output logic         flag_o,
    output logic         br_take_o
);
    flag_state_t st_d, st_q;

    logic [W-1:0] lsh_res, core_res, rsh_res;
    logic         lsh_bit, rsh_bit, cond_w, cin_w;
    alu_stat_t    core_stat;

    always_comb begin
        unique case (cin_sel_i)
            CIN_ZERO:  cin_w = 1'b0;
            CIN_ONE:   cin_w = 1'b1;
            CIN_FLAG:  cin_w = st_q.flag;
            default:   cin_w = !st_q.flag;
        endcase
    end

    alu_lshift #(.W(W)) i_lsh (
        .a_i(opa_i), .en_i(shl_i), .a_o(lsh_res), .out_bit_o(lsh_bit)
    );

    alu_core #(.W(W)) i_core (
        .a_i(lsh_res), .b_i(opb_i), .op_i(op_i), .lfn_i(lfn_i),
        .cin_i(cin_w), .flag_i(st_q.flag), .res_o(core_res), .stat_o(core_stat)
    );

    alu_rshift #(.W(W)) i_rsh (
        .r_i(core_res), .fill_i(core_stat.carry), .en_i(shr_i),
        .r_o(rsh_res), .out_bit_o(rsh_bit)
    );

    alu_cond #(.W(W)) i_cond (
        .f_i(core_res), .stat_i(core_stat), .sel_i(cond_sel_i), .cond_o(cond_w)
    );

    always_comb begin
        st_d = st_q;
        unique case (flag_ld_i)
            FLD_COND: st_d.flag = cond_w;
            FLD_LSH:  st_d.flag = lsh_bit;
            FLD_RSH:  st_d.flag = rsh_bit;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_word_o = {W{st_d.flag}};
    assign res_o       = fw_sel_i ? flag_word_o : rsh_res;
    assign flag_o      = st_q.flag;
    assign br_take_o   = !st_q.flag;

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ld_i == FLD_HOLD) |=> (flag_o == $past(flag_o)));

    // R7
    flag_cond_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ld_i == FLD_COND) |=> (flag_o == $past(cond_w)));

    // R7
    flag_rsh_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ld_i == FLD_RSH) |=> (flag_o == $past(core_res[0])));

    // R9
    flag_word_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fw_sel_i |-> (res_o == flag_word_o));

    // R5
    cadd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_CADD) && !flag_o) |-> (core_res == lsh_res && !core_stat.carry));

    // R3
    lsh_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shl_i |-> (lsh_bit == opa_i[W-1] && lsh_res[0] == 1'b0));

    // R6
    cond_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel_i == 4'd1 && flag_ld_i == FLD_COND) |=> flag_o);
endmodule

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;
    localparam int W = 32;

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  lfn;
        logic [1:0]  cin;
        logic        shl;
        logic        shr;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 4'b1000, 2'd0, 1'b0, 1'b0, 32'hF0F0_1234, 32'hFF00_FF00, 32'hF000_1200}, // R1 and
        '{3'd0, 4'b0110, 2'd0, 1'b0, 1'b0, 32'hAAAA_AAAA, 32'hFFFF_0000, 32'h5555_AAAA}, // R1 xor
        '{3'd0, 4'b0011, 2'd0, 1'b0, 1'b0, 32'h0000_FFFF, 32'h1234_5678, 32'hFFFF_0000}, // R1 not a
        '{3'd0, 4'b0001, 2'd0, 1'b0, 1'b0, 32'h0F0F_0000, 32'h00FF_00FF, 32'hF000_FF00}, // R1 nor
        '{3'd1, 4'b0000, 2'd0, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000}, // R2
        '{3'd1, 4'b0000, 2'd1, 1'b0, 1'b0, 32'h0000_0001, 32'h0000_0002, 32'h0000_0004}, // R2
        '{3'd2, 4'b0000, 2'd1, 1'b0, 1'b0, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE}, // R2
        '{3'd1, 4'b0000, 2'd0, 1'b1, 1'b0, 32'h8000_0003, 32'h0000_0001, 32'h0000_0007}, // R3
        '{3'd1, 4'b0000, 2'd0, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0003, 32'h8000_0001}, // R4
        '{3'd0, 4'b1100, 2'd0, 1'b0, 1'b1, 32'h0000_0005, 32'h0000_0000, 32'h0000_0002}, // R4
        '{3'd3, 4'b0000, 2'd0, 1'b0, 1'b1, 32'h0000_000A, 32'h0000_0005, 32'h0000_0005}, // R5
        '{3'd4, 4'b0000, 2'd0, 1'b1, 1'b0, 32'h0000_0008, 32'h0000_0003, 32'h0000_0010}, // R5
        '{3'd5, 4'b0000, 2'd0, 1'b1, 1'b0, 32'h1234_5678, 32'h0000_FFFF, 32'h2468_ACF0}, // R12
        '{3'd2, 4'b0000, 2'd0, 1'b0, 1'b0, 32'h0000_0005, 32'h0000_0002, 32'h0000_0002}, // R2
        '{3'd1, 4'b0000, 2'd3, 1'b0, 1'b0, 32'h0000_0001, 32'h0000_0001, 32'h0000_0003}  // R2
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  opa_i = '0, opb_i = '0;
    logic [2:0]    op_i = '0;
    logic [3:0]    lfn_i = '0;
    logic [1:0]    cin_sel_i = '0;
    logic          shl_i = 1'b0, shr_i = 1'b0;
    logic [3:0]    cond_sel_i = '0;
    logic [1:0]    flag_ld_i = '0;
    logic          fw_sel_i = 1'b0;
    logic [W-1:0]  res_o, flag_word_o;
    logic          flag_o, br_take_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alu_flag_unit #(.W(W)) i_alu_flag_unit (
        .clk(clk), .rst_n(rst_n), .opa_i(opa_i), .opb_i(opb_i), .op_i(op_i),
        .lfn_i(lfn_i), .cin_sel_i(cin_sel_i), .shl_i(shl_i), .shr_i(shr_i),
        .cond_sel_i(cond_sel_i), .flag_ld_i(flag_ld_i), .fw_sel_i(fw_sel_i),
        .res_o(res_o), .flag_word_o(flag_word_o), .flag_o(flag_o), .br_take_o(br_take_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [3:0] lfn, input logic [1:0] cin,
                         input logic shl, input logic shr, input logic [3:0] cs,
                         input logic [1:0] fld, input logic fw,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_i = op; lfn_i = lfn; cin_sel_i = cin; shl_i = shl; shr_i = shr;
        cond_sel_i = cs; flag_ld_i = fld; fw_sel_i = fw; opa_i = a; opb_i = b;
        #1;
    endtask

    // apply an op that loads the flag, then check the stored flag after the edge
    task automatic flag_op(input string req, input logic [2:0] op, input logic [1:0] cin,
                           input logic shl, input logic shr, input logic [3:0] cs,
                           input logic [1:0] fld, input logic [31:0] a,
                           input logic [31:0] b, input logic exp);
        drive(op, 4'b0000, cin, shl, shr, cs, fld, 1'b0, a, b);
        @(posedge clk); #1;
        chk(req, {31'b0, flag_o}, {31'b0, exp});
        flag_ld_i = 2'd0;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        // R11 reset state
        chk("R11 flag", {31'b0, flag_o}, 32'd0);
        chk("R11 br_take", {31'b0, br_take_o}, 32'd1);
        chk("R11 flag_word", flag_word_o, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].lfn, VECS[i].cin, VECS[i].shl, VECS[i].shr,
                  4'd0, 2'd0, 1'b0, VECS[i].a, VECS[i].b);
            chk($sformatf("R1-table row %0d", i), res_o, VECS[i].exp);
        end

        // R6 condition codes
        flag_op("R6 Z",   3'd2, 2'd1, 0, 0, 4'd2,  2'd1, 32'd3, 32'd3, 1'b1);
        chk("R10 br_take", {31'b0, br_take_o}, 32'd0);
        flag_op("R6 NZ",  3'd2, 2'd1, 0, 0, 4'd3,  2'd1, 32'd3, 32'd3, 1'b0);
        chk("R10 br_take", {31'b0, br_take_o}, 32'd1);
        flag_op("R6 LS",  3'd2, 2'd1, 0, 0, 4'd12, 2'd1, 32'd3, 32'd3, 1'b1);
        flag_op("R6 HI",  3'd2, 2'd1, 0, 0, 4'd13, 2'd1, 32'd3, 32'd3, 1'b0);
        flag_op("R6 NC",  3'd2, 2'd1, 0, 0, 4'd7,  2'd1, 32'd2, 32'd5, 1'b1);
        flag_op("R6 LT",  3'd2, 2'd1, 0, 0, 4'd10, 2'd1, 32'd2, 32'd5, 1'b1);
        flag_op("R6 HI2", 3'd2, 2'd1, 0, 0, 4'd13, 2'd1, 32'd2, 32'd5, 1'b0);
        flag_op("R6 V",   3'd1, 2'd0, 0, 0, 4'd8,  2'd1, 32'h7FFF_FFFF, 32'd1, 1'b1);
        flag_op("R6 LTV", 3'd1, 2'd0, 0, 0, 4'd10, 2'd1, 32'h7FFF_FFFF, 32'd1, 1'b0);
        flag_op("R6 N",   3'd1, 2'd0, 0, 0, 4'd4,  2'd1, 32'h7FFF_FFFF, 32'd1, 1'b1);
        flag_op("R6 GT",  3'd2, 2'd1, 0, 0, 4'd15, 2'd1, 32'd5, 32'd2, 1'b1);
        flag_op("R6 LE",  3'd2, 2'd1, 0, 0, 4'd14, 2'd1, 32'd5, 32'd2, 1'b0);
        flag_op("R6 C",   3'd1, 2'd0, 0, 0, 4'd6,  2'd1, 32'hFFFF_FFFF, 32'd1, 1'b1);
        flag_op("R6 F",   3'd1, 2'd0, 0, 0, 4'd0,  2'd1, 32'd0, 32'd0, 1'b0);
        flag_op("R6 T",   3'd1, 2'd0, 0, 0, 4'd1,  2'd1, 32'd0, 32'd0, 1'b1);

        // R8 hold: condition would be false, flag must stay 1
        flag_op("R8 hold", 3'd2, 2'd1, 0, 0, 4'd3, 2'd0, 32'd3, 32'd3, 1'b1);
        @(posedge clk); #1;
        chk("R8 hold2", {31'b0, flag_o}, 32'd1);

        // R2 flag as carry (flag = 1)
        drive(3'd1, 4'd0, 2'd2, 0, 0, 4'd0, 2'd0, 1'b0, 32'd1, 32'd1);
        chk("R2 cin flag", res_o, 32'd3);
        drive(3'd1, 4'd0, 2'd3, 0, 0, 4'd0, 2'd0, 1'b0, 32'd1, 32'd1);
        chk("R2 cin nflag", res_o, 32'd2);

        // R5 conditional ops with flag = 1
        drive(3'd3, 4'd0, 2'd0, 0, 0, 4'd0, 2'd0, 1'b0, 32'h10, 32'd5);
        chk("R5 cadd on", res_o, 32'h15);
        drive(3'd4, 4'd0, 2'd0, 1, 0, 4'd0, 2'd0, 1'b0, 32'd8, 32'd3);
        chk("R5 csub on", res_o, 32'hD);
        drive(3'd3, 4'd0, 2'd0, 0, 1, 4'd0, 2'd0, 1'b0, 32'hFFFF_FFFF, 32'd1);
        chk("R5 R4 mul step", res_o, 32'h8000_0000);

        // R7 shift-out sources
        flag_op("R7 lsh0", 3'd5, 2'd0, 1, 0, 4'd0, 2'd2, 32'h4000_0000, 32'd0, 1'b0);
        flag_op("R7 lsh1", 3'd5, 2'd0, 1, 0, 4'd0, 2'd2, 32'h8000_0000, 32'd0, 1'b1);
        flag_op("R7 rsh0", 3'd1, 2'd0, 0, 1, 4'd0, 2'd3, 32'd2, 32'd0, 1'b0);
        flag_op("R7 rsh1", 3'd1, 2'd0, 0, 1, 4'd0, 2'd3, 32'd3, 32'd0, 1'b1);

        // R9 flag word uses the value being loaded
        drive(3'd1, 4'd0, 2'd0, 0, 0, 4'd0, 2'd1, 1'b1, 32'd7, 32'd7);
        chk("R9 fw new0 res", res_o, 32'd0);
        chk("R9 fw new0 word", flag_word_o, 32'd0);
        @(posedge clk); #1;
        chk("R10 br after clear", {31'b0, br_take_o}, 32'd1);
        drive(3'd1, 4'd0, 2'd0, 0, 0, 4'd1, 2'd1, 1'b1, 32'd7, 32'd7);
        chk("R9 fw new1 res", res_o, 32'hFFFF_FFFF);
        @(posedge clk); #1;
        drive(3'd1, 4'd0, 2'd0, 0, 0, 4'd0, 2'd0, 1'b1, 32'd7, 32'd7);
        chk("R9 fw held", res_o, 32'hFFFF_FFFF);
        chk("R10 flag_o", {31'b0, flag_o}, 32'd1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule